// File: doc/BRIEF.md
# Dual-Port Mailbox Memory

This block is a 4096-word memory with two independent ports, A and B. It also has one interrupt flag per port for port-to-port signalling. Each port has an active-low enable, an active-low write strobe, an active-low output enable, a 12-bit address, a write-data bus and a registered read-data bus. Everything runs on one clock. A read returns its word one cycle after the access.

The two highest words double as mailboxes:

- Word 0xFFF is the inbox of port B. A write to it by port A raises the interrupt of B. A read of it by B lowers that interrupt again.
- Word 0xFFE is the inbox of port A. A write to it by B raises the interrupt of A. A read of it by A lowers it.

The mailbox words are still ordinary memory, so the message is whatever data the sender stored. No register controls the flags: they change only as a side effect of these accesses.

Each flag is a two-state machine with the states FLAG_CLEAR and FLAG_RAISED. The transitions are:

- RAISE: from FLAG_CLEAR when the peer writes the inbox.
- DROP: from FLAG_RAISED when the owner reads the inbox in a cycle without a RAISE.
- In every other case the state holds.

Each port decoder classifies a cycle as OP_IDLE, OP_READ or OP_WRITE.

Top module: `mbox_dpram`

## Requirements
- R1: After reset both interrupt outputs are high (deasserted) and both read-data buses are zero.
- R2: With enable low and write strobe low, the port stores its write data at its address; the output enable has no effect on a write.
- R3: With enable low, write strobe high and output enable low, the port's read data shows the addressed word after the next clock edge; in any cycle without such a read, the read data holds its value.
- R4: A cycle with enable high, or with enable low but both write strobe and output enable high, changes neither memory nor read data.
- R5: A write by port A to 0xFFF drives `b_irq_n` low from the next clock edge.
- R6: A read by port B of 0xFFF drives `b_irq_n` high from the next clock edge, unless the flag is raised in that same cycle.
- R7: A write by port B to 0xFFE drives `a_irq_n` low. A later read by port A of 0xFFE drives it high again.
- R8: A read of a mailbox word returns the message data the sender wrote there.
- R9: The flags are untouched by these accesses:
  - a port writing its own inbox;
  - a port reading the other port's inbox;
  - the sending port reading the mailbox word it wrote.
- R10: If a flag is raised and cleared in the same cycle, it ends up raised (low).
- R11: A flag holds its level through any number of cycles with neither a raise nor a clear.
- R12: When both ports write the same address in one cycle, port B's data is kept.
- R13: A read in the same cycle as the other port's write to that address returns the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_en_n | input | 1 | Port A enable, active low |
| a_wr_n | input | 1 | Port A write strobe, active low |
| a_oe_n | input | 1 | Port A output enable, active low |
| a_addr | input | 12 | Port A word address |
| a_wdata | input | 8 | Port A write data |
| a_rdata | output | 8 | Port A registered read data |
| a_irq_n | output | 1 | Port A interrupt, active low |
| b_en_n | input | 1 | Port B enable, active low |
| b_wr_n | input | 1 | Port B write strobe, active low |
| b_oe_n | input | 1 | Port B output enable, active low |
| b_addr | input | 12 | Port B word address |
| b_wdata | input | 8 | Port B write data |
| b_rdata | output | 8 | Port B registered read data |
| b_irq_n | output | 1 | Port B interrupt, active low |

## Verification
Some flag behaviour is checked on every cycle by assertions in the RTL:
- a raise always wins over a same-cycle clear;
- a lone clear always releases the flag;
- a flag holds when nothing touches it;
- a port writing its own inbox never moves its own flag;
- read data stays put in cycles with no read.

Other behaviour depends on data flowing through the memory, and only the bench's scenarios show it:
- the contents of a mailbox message;
- the ordering between a read and the other port's write in the same cycle;
- port B winning a write collision;
- accesses that are not enabled leaving the memory unchanged.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } port_op_e;

    typedef enum logic {
        FLAG_CLEAR  = 1'b0,
        FLAG_RAISED = 1'b1
    } flag_state_e;

endpackage

// File: rtl/mbox_port_dec.sv
module mbox_port_dec
    import mbox_pkg::*;
#(
    parameter int                ADDR_W = 12,
    parameter logic [ADDR_W-1:0] INBOX  = '1,
    parameter logic [ADDR_W-1:0] OUTBOX = '0
) (
    input  logic              en_n,
    input  logic              wr_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    output port_op_e          op,
    output logic              rd_inbox,
    output logic              wr_outbox
);

    always_comb begin
        unique casez ({en_n, wr_n, oe_n})
            3'b1??:  op = OP_IDLE;
            3'b00?:  op = OP_WRITE;
            3'b010:  op = OP_READ;
            3'b011:  op = OP_IDLE;
            default: op = OP_IDLE;
        endcase
    end

    always_comb begin
        rd_inbox  = (op == OP_READ)  && (addr == INBOX);
        wr_outbox = (op == OP_WRITE) && (addr == OUTBOX);
    end

endmodule

// File: rtl/mbox_flag.sv
module mbox_flag
    import mbox_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic irq_n
);

    flag_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FLAG_CLEAR;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLAG_CLEAR:  if (set_i)           state_d = FLAG_RAISED;
            FLAG_RAISED: if (clr_i && !set_i) state_d = FLAG_CLEAR;
            default:                          state_d = FLAG_CLEAR;
        endcase
    end

    always_comb irq_n = (state_q != FLAG_RAISED);

    p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> !irq_n);

    p_clear_releases_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> irq_n);

    p_flag_holds_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_i && !clr_i) |=> $stable(irq_n));

endmodule

// File: rtl/mbox_mem.sv
module mbox_mem #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 8,
    parameter int PORTS  = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [PORTS-1:0]             we,
    input  logic [PORTS-1:0]             re,
    input  logic [PORTS-1:0][ADDR_W-1:0] addr,
    input  logic [PORTS-1:0][DATA_W-1:0] wd,
    output logic [PORTS-1:0][DATA_W-1:0] rd
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Higher-numbered port is applied last, so it wins a same-address collision.
    always_ff @(posedge clk) begin
        for (int p = 0; p < PORTS; p++) begin
            if (we[p]) mem[addr[p]] <= wd[p];
        end
    end

    for (genvar p = 0; p < PORTS; p++) begin : g_rd
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     rd[p] <= '0;
            else if (re[p]) rd[p] <= mem[addr[p]];
        end

        p_rdata_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
            !re[p] |=> $stable(rd[p]));
    end

endmodule

// File: rtl/mbox_dpram.sv
module mbox_dpram
    import mbox_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_en_n,
    input  logic              a_wr_n,
    input  logic              a_oe_n,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [DATA_W-1:0] a_wdata,
    output logic [DATA_W-1:0] a_rdata,
    output logic              a_irq_n,
    input  logic              b_en_n,
    input  logic              b_wr_n,
    input  logic              b_oe_n,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [DATA_W-1:0] b_wdata,
    output logic [DATA_W-1:0] b_rdata,
    output logic              b_irq_n
);

    localparam int                NP      = 2;
    localparam logic [ADDR_W-1:0] MB_TO_B = ADDR_W'((1 << ADDR_W) - 1);
    localparam logic [ADDR_W-1:0] MB_TO_A = ADDR_W'((1 << ADDR_W) - 2);

    logic [NP-1:0]             en_n_w, wr_n_w, oe_n_w;
    logic [NP-1:0][ADDR_W-1:0] addr_w;
    logic [NP-1:0][DATA_W-1:0] wd_w, rd_w;
    logic [NP-1:0]             we_w, re_w, rd_inbox_w, wr_outbox_w, irq_n_w;
    port_op_e                  op_w [NP];

    assign en_n_w = {b_en_n, a_en_n};
    assign wr_n_w = {b_wr_n, a_wr_n};
    assign oe_n_w = {b_oe_n, a_oe_n};
    assign addr_w = {b_addr, a_addr};
    assign wd_w   = {b_wdata, a_wdata};

    for (genvar p = 0; p < NP; p++) begin : g_port
        mbox_port_dec #(
            .ADDR_W (ADDR_W),
            .INBOX  ((p == 0) ? MB_TO_A : MB_TO_B),
            .OUTBOX ((p == 0) ? MB_TO_B : MB_TO_A)
        ) u_dec (
            .en_n      (en_n_w[p]),
            .wr_n      (wr_n_w[p]),
            .oe_n      (oe_n_w[p]),
            .addr      (addr_w[p]),
            .op        (op_w[p]),
            .rd_inbox  (rd_inbox_w[p]),
            .wr_outbox (wr_outbox_w[p])
        );

        assign we_w[p] = (op_w[p] == OP_WRITE);
        assign re_w[p] = (op_w[p] == OP_READ);

        mbox_flag u_flag (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (wr_outbox_w[NP-1-p]),
            .clr_i (rd_inbox_w[p]),
            .irq_n (irq_n_w[p])
        );
    end

    mbox_mem #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .PORTS  (NP)
    ) u_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (we_w),
        .re    (re_w),
        .addr  (addr_w),
        .wd    (wd_w),
        .rd    (rd_w)
    );

    assign a_rdata = rd_w[0];
    assign b_rdata = rd_w[1];
    assign a_irq_n = irq_n_w[0];
    assign b_irq_n = irq_n_w[1];

    p_own_inbox_write_a_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!a_en_n && !a_wr_n && a_addr == MB_TO_A &&
         !(!b_en_n && !b_wr_n && b_addr == MB_TO_A)) |=> $stable(a_irq_n));

    p_own_inbox_write_b_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!b_en_n && !b_wr_n && b_addr == MB_TO_B &&
         !(!a_en_n && !a_wr_n && a_addr == MB_TO_B)) |=> $stable(b_irq_n));

endmodule

// File: tb/mbox_dpram_bench.sv
module mbox_dpram_bench;

    localparam int PERIOD = 10;
    localparam int IDLE = 0, RD = 1, WR = 2, NOP = 3, WROE = 4, OFFWR = 5;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        a_en_n, a_wr_n, a_oe_n, b_en_n, b_wr_n, b_oe_n;
    logic [11:0] a_addr, b_addr;
    logic [7:0]  a_wdata, b_wdata, a_rdata, b_rdata;
    logic        a_irq_n, b_irq_n;
    int          n_chk = 0;
    int          n_err = 0;
    bit          done = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    mbox_dpram u_mbox_dpram (
        .clk(clk), .rst_n(rst_n),
        .a_en_n(a_en_n), .a_wr_n(a_wr_n), .a_oe_n(a_oe_n), .a_addr(a_addr),
        .a_wdata(a_wdata), .a_rdata(a_rdata), .a_irq_n(a_irq_n),
        .b_en_n(b_en_n), .b_wr_n(b_wr_n), .b_oe_n(b_oe_n), .b_addr(b_addr),
        .b_wdata(b_wdata), .b_rdata(b_rdata), .b_irq_n(b_irq_n)
    );

    // {en_n, wr_n, oe_n}
    function automatic logic [2:0] ctl(int op);
        case (op)
            RD:      return 3'b010;
            WR:      return 3'b001;
            NOP:     return 3'b011;
            WROE:    return 3'b000;
            OFFWR:   return 3'b100;
            default: return 3'b111;
        endcase
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(int aop, logic [11:0] aa, logic [7:0] ad,
                        int bop, logic [11:0] ba, logic [7:0] bd);
        {a_en_n, a_wr_n, a_oe_n} = ctl(aop);
        a_addr = aa; a_wdata = ad;
        {b_en_n, b_wr_n, b_oe_n} = ctl(bop);
        b_addr = ba; b_wdata = bd;
        @(posedge clk); #1;
        {a_en_n, a_wr_n, a_oe_n} = 3'b111;
        {b_en_n, b_wr_n, b_oe_n} = 3'b111;
    endtask

    task automatic t_reset;
        check("R1 a_irq_n", a_irq_n, 1);
        check("R1 b_irq_n", b_irq_n, 1);
        check("R1 a_rdata", a_rdata, 0);
        check("R1 b_rdata", b_rdata, 0);
    endtask

    task automatic t_rw;
        step(WR, 12'h123, 8'h5A, IDLE, 0, 0);
        step(RD, 12'h123, 0, RD, 12'h123, 0);
        check("R3 a read", a_rdata, 8'h5A);
        check("R3 b read", b_rdata, 8'h5A);
        step(IDLE, 0, 0, IDLE, 0, 0);
        check("R3 hold", a_rdata, 8'h5A);
        step(WROE, 12'h124, 8'h77, IDLE, 0, 0);
        step(RD, 12'h124, 0, IDLE, 0, 0);
        check("R2 write with oe", a_rdata, 8'h77);
    endtask

    task automatic t_noacc;
        step(OFFWR, 12'h123, 8'hFF, NOP, 12'h123, 8'hEE);
        check("R4 no read", a_rdata, 8'h77);
        check("R4 no read b", b_rdata, 8'h5A);
        step(RD, 12'h123, 0, IDLE, 0, 0);
        check("R4 memory unchanged", a_rdata, 8'h5A);
    endtask

    task automatic t_mbox_b;
        step(WR, 12'hFFF, 8'hC3, IDLE, 0, 0);
        check("R5 b_irq_n set", b_irq_n, 0);
        check("R9 a_irq_n untouched", a_irq_n, 1);
        step(RD, 12'hFFF, 0, IDLE, 0, 0);
        check("R9 sender read keeps flag", b_irq_n, 0);
        step(IDLE, 0, 0, RD, 12'hFFF, 0);
        check("R8 message b", b_rdata, 8'hC3);
        check("R6 b_irq_n cleared", b_irq_n, 1);
    endtask

    task automatic t_mbox_a;
        step(IDLE, 0, 0, WR, 12'hFFE, 8'h3C);
        check("R7 a_irq_n set", a_irq_n, 0);
        for (int i = 0; i < 3; i++) step(IDLE, 0, 0, IDLE, 0, 0);
        check("R11 flag holds", a_irq_n, 0);
        step(IDLE, 0, 0, RD, 12'hFFE, 0);
        check("R9 peer inbox read", a_irq_n, 0);
        step(RD, 12'hFFE, 0, IDLE, 0, 0);
        check("R8 message a", a_rdata, 8'h3C);
        check("R7 a_irq_n cleared", a_irq_n, 1);
    endtask

    task automatic t_wrong;
        step(WR, 12'hFFE, 8'h44, WR, 12'hFFF, 8'h55);
        check("R9 A writes own inbox", a_irq_n, 1);
        check("R9 B writes own inbox", b_irq_n, 1);
    endtask

    task automatic t_setwins;
        step(WR, 12'hFFF, 8'h66, IDLE, 0, 0);
        check("R5 set again", b_irq_n, 0);
        step(WR, 12'hFFF, 8'h99, RD, 12'hFFF, 0);
        check("R10 set wins b", b_irq_n, 0);
        check("R13 old data b", b_rdata, 8'h66);
        step(IDLE, 0, 0, RD, 12'hFFF, 0);
        check("R6 clear after", b_irq_n, 1);
        check("R8 new message", b_rdata, 8'h99);
        step(RD, 12'hFFE, 0, WR, 12'hFFE, 8'h12);
        check("R10 set wins a", a_irq_n, 0);
        check("R13 old data a", a_rdata, 8'h44);
        step(RD, 12'hFFE, 0, IDLE, 0, 0);
        check("R7 clear a", a_irq_n, 1);
    endtask

    task automatic t_collide;
        step(WR, 12'h040, 8'hA1, WR, 12'h040, 8'hB2);
        step(RD, 12'h040, 0, RD, 12'h040, 0);
        check("R12 b wins a view", a_rdata, 8'hB2);
        check("R12 b wins b view", b_rdata, 8'hB2);
        step(WR, 12'h050, 8'h11, IDLE, 0, 0);
        step(WR, 12'h050, 8'h22, RD, 12'h050, 0);
        check("R13 read first", b_rdata, 8'h11);
        step(IDLE, 0, 0, RD, 12'h050, 0);
        check("R2 later write", b_rdata, 8'h22);
    endtask

    initial begin
        #(PERIOD * 100000);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        {a_en_n, a_wr_n, a_oe_n} = 3'b111;
        {b_en_n, b_wr_n, b_oe_n} = 3'b111;
        a_addr = '0; b_addr = '0; a_wdata = '0; b_wdata = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_rw();
        t_noacc();
        t_mbox_b();
        t_mbox_a();
        t_wrong();
        t_setwins();
        t_collide();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule